// File: doc/BRIEF.md
# I2C Transfer Bit Counter and Reference Clock Divider

This block is the bit-accounting and clock-select register of an I2C controller. It tracks how many SCL cycles of the current byte remain, including the acknowledge slot. It does this from the rising-edge events and the start/repeated-start event that the bus logic supplies. When the last bit of the byte ends, it flags that the byte is complete. The same 8-bit register also holds two more fields. One picks the divider that produces the controller's reference clock enable. The other gates writes to the master and transmit mode bits of a neighbouring control register.

The remaining-bit count lives in a three-state machine:

- `BC_IDLE`: the count reads 000.
- `BC_COUNT`: counting down.
- `BC_FINAL`: the last bit is pending and the count still reads 001.

The state changes as follows:

- `BC_IDLE -> BC_COUNT` on a rising edge, with the count becoming 111.
- `BC_COUNT -> BC_COUNT` on a rising edge while the count is above 001; the count drops by one.
- `BC_COUNT -> BC_FINAL` on a rising edge at 001.
- `BC_FINAL -> BC_IDLE` on a rising edge; this also raises the done pulse.
- From any state to `BC_IDLE` on a start or restart event, or on a software load of 000.
- From any state to `BC_COUNT` on a software load of a nonzero value.

Software may reload the count between bytes while SCL is low, to shorten the next byte. The value written is the data bit count plus one, to cover the acknowledge slot.

Top module: `i2c_bitctl_regs`

## Requirements
- R1: After reset the register reads 0x08 and `bits_left` is 000. `byte_done` and `mode_wr_allow` are 0, and `ref_clk_en` is high in every cycle (divide by 1).
- R2: The read value is laid out as follows: bits 2:0 hold the count, bit 3 always reads 1, bits 6:4 hold the clock select, and bit 7 holds the mode-write-enable bit.
- R3: A write loads bits 2:0 into the count only when its bit 3 is 0 and `scl_level` is low. The new count shows on the next cycle. A load of 000 returns to `BC_IDLE`; any other value enters `BC_COUNT`.
- R4: A write whose bit 3 is 1, or any write made while `scl_level` is high, leaves the count unchanged.
- R5: In `BC_IDLE` a rising edge moves the count to 111. In `BC_COUNT` with a count above 001, a rising edge lowers it by one.
- R6: A rising edge at count 001 in `BC_COUNT` enters `BC_FINAL` and the count stays 001. The next rising edge sets the count to 000 and raises `byte_done` for exactly one cycle. A byte therefore takes 9 rising edges from 000, and v+1 rising edges from a loaded value v of 1 to 7.
- R7: A start or restart event clears the count to 000 in the next cycle without raising `byte_done`. It takes priority over a rising edge and over a write in the same cycle.
- R8: A qualifying count write takes priority over a rising edge in the same cycle.
- R9: With clock select s, `ref_clk_en` is a one-cycle pulse repeating every 2^s cycles (s = 0 gives a pulse every cycle, s = 7 gives one every 128).
- R10: A write that changes the clock select restarts the divider. The first pulse appears 2^s - 1 cycles after the first cycle that shows the new select.
- R11: Every write updates the clock select and the mode-write-enable bit, whatever bit 3 holds and whatever the SCL level. `mode_wr_allow` shows bit 7 of the last write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| scl_level | input | 1 | Current SCL line level |
| scl_rise | input | 1 | One-cycle SCL rising-edge event |
| start_det | input | 1 | One-cycle start or repeated-start event |
| bits_left | output | 3 | Remaining-bit count (000 means nine) |
| byte_done | output | 1 | One-cycle pulse at the end of a byte plus acknowledge |
| ref_clk_en | output | 1 | Divided reference clock enable pulse |
| mode_wr_allow | output | 1 | Qualifier allowing writes to the master and transmit bits |

## Verification
A wrong counter state shows on `bits_left` and the count bits of `reg_rdata` in the cycle after the edge that caused it. A missing or extra `BC_FINAL` phase shows up as `byte_done` arriving one edge early or late in the same byte. A divider fault shows as a pulse gap other than 2^s, which becomes visible within at most 128 cycles of the select being written. The bench therefore compares every output in every cycle against a model built from the requirements, so a fault is reported at its first visible cycle.

// File: rtl/i2c_bitctl_pkg.sv
`timescale 1ns/1ps
package i2c_bitctl_pkg;

    localparam int CNT_W = 3;
    localparam int SEL_W = 3;

    // Field positions inside the 8-bit register.
    localparam int CNT_LSB = 0;
    localparam int WP_BIT  = CNT_LSB + CNT_W;
    localparam int SEL_LSB = WP_BIT + 1;
    localparam int MWP_BIT = SEL_LSB + SEL_W;
    localparam int REG_W   = MWP_BIT + 1;

    typedef enum logic [1:0] {
        BC_IDLE  = 2'd0,
        BC_COUNT = 2'd1,
        BC_FINAL = 2'd2
    } bc_state_e;

endpackage

// File: rtl/i2c_bitcnt_fsm.sv
`timescale 1ns/1ps
module i2c_bitcnt_fsm
    import i2c_bitctl_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          scl_rise,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] bits_left,
    output logic          byte_done
);

    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [CW-1:0] CNT_ZERO = '0;
    localparam logic [CW-1:0] CNT_FULL = '1;

    bc_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done_q, done_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BC_IDLE;
            cnt_q   <= CNT_ZERO;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    // Next state and registered outputs; start wins, then load, then edge
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        if (start_det) begin
            state_d = BC_IDLE;
            cnt_d   = CNT_ZERO;
        end else if (load_en) begin
            cnt_d   = load_val;
            state_d = (load_val == CNT_ZERO) ? BC_IDLE : BC_COUNT;
        end else if (scl_rise) begin
            unique case (state_q)
                BC_IDLE: begin
                    state_d = BC_COUNT;
                    cnt_d   = CNT_FULL;
                end
                BC_COUNT: begin
                    if (cnt_q == CNT_ONE) begin
                        state_d = BC_FINAL;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                BC_FINAL: begin
                    state_d = BC_IDLE;
                    cnt_d   = CNT_ZERO;
                    done_d  = 1'b1;
                end
                default: begin
                    state_d = BC_IDLE;
                    cnt_d   = CNT_ZERO;
                end
            endcase
        end
    end

    assign bits_left = cnt_q;
    assign byte_done = done_q;

endmodule

// File: rtl/i2c_ctl_fields.sv
`timescale 1ns/1ps
module i2c_ctl_fields
    import i2c_bitctl_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [SW-1:0] wr_sel,
    input  logic          wr_mwp,
    output logic [SW-1:0] sel,
    output logic          mwp,
    output logic          sel_restart
);

    logic [SW-1:0] sel_q;
    logic          mwp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            mwp_q <= 1'b0;
        end else if (reg_we) begin
            sel_q <= wr_sel;
            mwp_q <= wr_mwp;
        end
    end

    always_comb begin
        sel_restart = reg_we && (wr_sel != sel_q);
    end

    assign sel = sel_q;
    assign mwp = mwp_q;

endmodule

// File: rtl/i2c_ref_prescaler.sv
`timescale 1ns/1ps
module i2c_ref_prescaler
    import i2c_bitctl_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    input  logic          restart,
    output logic          tick
);

    localparam int DW = (1 << SW) - 1;

    logic [DW-1:0] div_q;
    logic [DW-1:0] limit;

    always_comb begin
        limit = DW'((32'd1 << sel) - 32'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || (div_q == limit)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    assign tick = (div_q == limit);

endmodule

// File: rtl/i2c_bitctl_regs.sv
`timescale 1ns/1ps
module i2c_bitctl_regs
    import i2c_bitctl_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          scl_level,
    input  logic          scl_rise,
    input  logic          start_det,
    output logic [CW-1:0] bits_left,
    output logic          byte_done,
    output logic          ref_clk_en,
    output logic          mode_wr_allow
);

    localparam int WPB = CW;
    localparam int SLB = CW + 1;
    localparam int MWB = CW + 1 + SW;

    logic          load_en;
    logic [SW-1:0] sel;
    logic          mwp;
    logic          sel_restart;

    always_comb begin
        load_en = reg_we && !reg_wdata[WPB] && !scl_level;
    end

    i2c_bitcnt_fsm #(.CW(CW)) u_bitcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .scl_rise  (scl_rise),
        .load_en   (load_en),
        .load_val  (reg_wdata[CW-1:0]),
        .bits_left (bits_left),
        .byte_done (byte_done)
    );

    i2c_ctl_fields #(.SW(SW)) u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .wr_sel      (reg_wdata[SLB +: SW]),
        .wr_mwp      (reg_wdata[MWB]),
        .sel         (sel),
        .mwp         (mwp),
        .sel_restart (sel_restart)
    );

    i2c_ref_prescaler #(.SW(SW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .restart (sel_restart),
        .tick    (ref_clk_en)
    );

    assign reg_rdata     = {mwp, sel, 1'b1, bits_left};
    assign mode_wr_allow = mwp;

endmodule

// File: rtl/i2c_bitctl_chk.sv
`timescale 1ns/1ps
module i2c_bitctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       scl_level,
    input logic       scl_rise,
    input logic       start_det,
    input logic [2:0] bits_left,
    input logic       byte_done,
    input logic       ref_clk_en,
    input logic       mode_wr_allow
);

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bits_left == 3'd0) && !byte_done);

    // R6
    done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (bits_left == 3'd0));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R4
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[3] && !scl_rise && !start_det) |=> $stable(bits_left));

    // R4
    scl_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && scl_level && !scl_rise && !start_det) |=> $stable(bits_left));

    // R11
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (mode_wr_allow == $past(reg_wdata[7])));

    // R2
    wp_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] == 1'b1);

    // R9
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clk_en && (reg_rdata[6:4] != 3'd0) && !reg_we) |=> !ref_clk_en);

endmodule

bind i2c_bitctl_regs i2c_bitctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .scl_level     (scl_level),
    .scl_rise      (scl_rise),
    .start_det     (start_det),
    .bits_left     (bits_left),
    .byte_done     (byte_done),
    .ref_clk_en    (ref_clk_en),
    .mode_wr_allow (mode_wr_allow)
);

// File: tb/test_i2c_bitctl_regs.sv
`timescale 1ns/1ps
module test_i2c_bitctl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       scl_level = 1'b0;
    logic       scl_rise = 1'b0;
    logic       start_det = 1'b0;
    logic [7:0] reg_rdata;
    logic [2:0] bits_left;
    logic       byte_done;
    logic       ref_clk_en;
    logic       mode_wr_allow;

    int n_chk = 0;
    int n_err = 0;

    // bench model state
    logic [2:0] m_cnt = 3'd0;
    logic       m_last = 1'b0;
    logic       m_done = 1'b0;
    logic [2:0] m_sel = 3'd0;
    logic       m_mwp = 1'b0;
    int         m_pcnt = 0;

    always #2 clk = ~clk;

    i2c_bitctl_regs i_i2c_bitctl_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .scl_level     (scl_level),
        .scl_rise      (scl_rise),
        .start_det     (start_det),
        .bits_left     (bits_left),
        .byte_done     (byte_done),
        .ref_clk_en    (ref_clk_en),
        .mode_wr_allow (mode_wr_allow)
    );

    function automatic int div_lim(input logic [2:0] s);
        return (1 << s) - 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        m_done = 1'b0;
        if (reg_we && (reg_wdata[6:4] != m_sel)) m_pcnt = 0;
        else if (m_pcnt == div_lim(m_sel)) m_pcnt = 0;
        else m_pcnt++;
        if (start_det) begin
            m_cnt = 3'd0; m_last = 1'b0;
        end else if (reg_we && !reg_wdata[3] && !scl_level) begin
            m_cnt = reg_wdata[2:0]; m_last = 1'b0;
        end else if (scl_rise) begin
            if (m_last) begin
                m_cnt = 3'd0; m_last = 1'b0; m_done = 1'b1;
            end else if (m_cnt == 3'd1) begin
                m_last = 1'b1;
            end else begin
                m_cnt = m_cnt - 3'd1;
            end
        end
        if (reg_we) begin
            m_sel = reg_wdata[6:4];
            m_mwp = reg_wdata[7];
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R5 bits_left", bits_left, m_cnt);
        chk("R6 byte_done", byte_done, m_done);
        chk("R9 ref_clk_en", ref_clk_en, (m_pcnt == div_lim(m_sel)) ? 1 : 0);
        chk("R11 mode_wr_allow", mode_wr_allow, m_mwp);
        chk("R2 readback", reg_rdata, {m_mwp, m_sel, 1'b1, m_cnt});
        reg_we = 1'b0; scl_rise = 1'b0; start_det = 1'b0;
    endtask

    task automatic rise_n(input int n);
        for (int i = 0; i < n; i++) begin
            scl_level = 1'b1; scl_rise = 1'b1; step();
            scl_level = 1'b0; step();
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d; step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h2c1d));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset rdata", reg_rdata, 8'h08);
        chk("R1 reset bits_left", bits_left, 0);
        chk("R1 reset byte_done", byte_done, 0);
        chk("R1 reset mode_wr_allow", mode_wr_allow, 0);
        chk("R1 reset ref_clk_en", ref_clk_en, 1);
        rst_n = 1'b1;
        step();
        chk("R1 divide-by-1 after reset", ref_clk_en, 1);

        // R6: nine edges from 000
        for (int i = 0; i < 8; i++) begin
            scl_level = 1'b1; scl_rise = 1'b1; step();
            chk("R5 count after edge", bits_left, (i == 7) ? 1 : 7 - i);
            chk("R6 no early done", byte_done, 0);
            scl_level = 1'b0; step();
        end
        scl_level = 1'b1; scl_rise = 1'b1; step();
        chk("R6 ninth edge done", byte_done, 1);
        chk("R6 ninth edge count", bits_left, 0);
        scl_level = 1'b0; step();
        chk("R6 done one cycle", byte_done, 0);

        // R3 load 3 -> four edges
        wr(8'h03);
        chk("R3 load value", bits_left, 3);
        rise_n(3);
        chk("R6 final phase holds 001", bits_left, 1);
        scl_level = 1'b1; scl_rise = 1'b1; step();
        chk("R6 done after v+1 edges", byte_done, 1);
        scl_level = 1'b0; step();

        // R4 protected write and write with SCL high
        wr(8'h0D);
        chk("R4 wp=1 ignored", bits_left, 0);
        scl_level = 1'b1; wr(8'h05);
        chk("R4 scl high ignored", bits_left, 0);
        chk("R11 sel still updated", reg_rdata[6:4], 0);
        scl_level = 1'b0;

        // R7 start clears, beats edge and write
        wr(8'h06);
        rise_n(2);
        start_det = 1'b1; scl_rise = 1'b1; scl_level = 1'b1; step();
        chk("R7 start over edge", bits_left, 0);
        scl_level = 1'b0;
        start_det = 1'b1; reg_we = 1'b1; reg_wdata = 8'h04; step();
        chk("R7 start over write", bits_left, 0);

        // R8 write beats edge (SCL low)
        scl_rise = 1'b1; reg_we = 1'b1; reg_wdata = 8'h02; step();
        chk("R8 write over edge", bits_left, 2);

        // R10 restart after select change to 3
        wr(8'hB2);
        chk("R11 mode bit set", mode_wr_allow, 1);
        begin
            int lows = 0;
            while (!ref_clk_en && lows < 300) begin lows++; step(); end
            chk("R10 first pulse delay", lows, 7);
        end
        // R9 gap for every select
        for (int s = 0; s < 8; s++) begin
            int gap = 0;
            wr({1'b0, 3'(s), 4'h8});
            while (!ref_clk_en && gap < 300) step();
            step(); gap = 1;
            while (!ref_clk_en && gap < 300) begin gap++; step(); end
            chk("R9 pulse period", gap, 1 << s);
        end

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            scl_level = $urandom_range(0, 1) == 1;
            scl_rise  = r < 35;
            start_det = (r % 23) == 0;
            reg_we    = ($urandom_range(0, 9) == 0);
            reg_wdata = 8'($urandom_range(0, 255));
            if (reg_we && $urandom_range(0, 3) != 0) reg_wdata[6:4] = m_sel;
            step();
        end

        summary();
        $finish;
    end

endmodule